// File: doc/BRIEF.md
# Multi-Length Arithmetic Unit with Condition Register

This block is the 16-bit arithmetic and logic stage of a small processor core. On each cycle with an operation strobe it combines the accumulator with an operand. It can add, subtract the accumulator from the operand, compare, AND, XOR, or pass a value through for a load or a store. The result is registered and marked valid for one cycle. A seven-bit condition register holds the flags and is updated in the same clock edge.

The unit supports chained arithmetic on values longer than one word. When the multi-length mode flag is set, the carry flag that the previous operation left behind is folded into the next addition or subtraction. A compare sets that mode flag, so a compare of the low words can be followed directly by arithmetic on the high words. The core can also act on the condition register without running an operation. It can clear the mode flag on a subroutine call, restore the lower six flags from a saved copy, or write any single flag bit.

Top module: `multiLengthAlu`

## Requirements
- R1: Operation code 0 (add) returns operand + accumulator, plus the carry flag when the mode flag is set. C takes the carry out of bit 15. V is set when both inputs have the same sign and the result sign differs from it.
- R2: Operation code 1 (subtract) returns operand − accumulator. When the mode flag is set it returns operand − accumulator + C − 1. C is 1 when no borrow occurs and 0 on a borrow. V is set when the input signs differ and the result sign equals the accumulator sign.
- R3: Operation code 2 (compare) updates C, V, Z and S exactly as a subtract does and sets the mode flag. It raises no result-valid, and the result output keeps its previous value.
- R4: Operation code 3 (AND) returns the bitwise AND and forces C to 1. Operation code 4 (XOR) returns the bitwise XOR and forces C to 0. Both leave V at its previous value.
- R5: Operation code 5 (load) returns the operand, and operation code 6 (store) returns the accumulator. Each sets Z and S from that value, clears V and keeps C.
- R6: Condition register bit positions are I=0, Z=1, V=2, S=3, C=4, M=5, F=6. For every recognised operation, Z is set when the 16-bit value is zero and S copies its bit 15. No operation changes I or F.
- R7: The result, result-valid and flags change on the clock edge that samples the strobe. Result-valid is high for exactly one cycle after each add, subtract, AND, XOR, load or store. Operation code 7, and any cycle without a strobe, leave the result and all flags unchanged.
- R8: The call strobe clears M and leaves every other flag as it was. It takes effect after any operation in the same cycle.
- R9: The restore strobe writes bits 5..0 of the condition register from the restore data and never changes F (bit 6). It takes effect after the operation and the call in the same cycle.
- R10: The bit-write strobe sets condition register bit bitIdx to bitVal and has the last word over everything else in that cycle. An index of 7 has no effect.
- R11: While reset is low, the result, result-valid and condition register are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe |
| opCode | input | 3 | Operation code (0 add .. 6 store) |
| accIn | input | 16 | Accumulator value |
| operandIn | input | 16 | Operand value |
| callStrobe | input | 1 | Clear the mode flag |
| restoreEn | input | 1 | Restore flags 5..0 |
| restoreData | input | 6 | Saved flag bits 5..0 |
| bitWrEn | input | 1 | Single flag bit write |
| bitIdx | input | 3 | Flag bit index |
| bitVal | input | 1 | Value for the flag bit |
| result | output | 16 | Registered result |
| resultValid | output | 1 | Result valid, one cycle |
| condReg | output | 7 | Condition register |

## Verification
An arithmetic operation and a direct condition register write can land in the same cycle and both target the flags. The bench provokes this by pairing a compare with a bit write that clears M, an add with the call strobe, and a restore with a bit write to the fail flag. Each outcome is judged against a model that applies the operation first, then the call, then the restore, then the bit write. Long chains of compare and subtract with the mode flag set check that the carry each step leaves behind is consumed by the next.

// File: rtl/mlalu_pkg.sv
package mlalu_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_CMP   = 3'd2,
    OP_AND   = 3'd3,
    OP_XOR   = 3'd4,
    OP_LOAD  = 3'd5,
    OP_STORE = 3'd6,
    OP_NONE  = 3'd7
  } aluOp_e;

  // flag positions inside the condition register
  localparam int FLAG_I = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_V = 2;
  localparam int FLAG_S = 3;
  localparam int FLAG_C = 4;
  localparam int FLAG_M = 5;
  localparam int FLAG_F = 6;

  // strobes from the control to the datapath
  typedef struct packed {
    logic fire;        // recognised operation: update Z and S
    logic arith;       // result taken from the adder
    logic isSub;       // adder runs operand - accumulator
    logic logicOp;     // result taken from the logic unit
    logic useXor;      // logic unit does XOR, else AND
    logic passOperand; // pass-through picks operand, else accumulator
    logic wrResult;    // load the result register and raise valid
    logic forceC;      // C forced to forceCVal
    logic forceCVal;
    logic clearV;
    logic setM;
    logic clrM;
    logic restore;
    logic bitWr;
  } aluCtrl_t;

endpackage

// File: rtl/mlaluCtrl.sv
module mlaluCtrl
  import mlalu_pkg::*;
#(
  parameter int CR_W  = 7,
  localparam int IDX_W = $clog2(CR_W + 1)
) (
  input  logic             opValid,
  input  logic [2:0]       opCode,
  input  logic             callStrobe,
  input  logic             restoreEn,
  input  logic             bitWrEn,
  input  logic [IDX_W-1:0] bitIdx,
  output aluCtrl_t         ctrl
);

  aluOp_e op;
  assign op = aluOp_e'(opCode);

  always_comb begin
    ctrl = '0;
    if (opValid) begin
      unique case (op)
        OP_ADD: begin
          ctrl.fire = 1'b1; ctrl.arith = 1'b1; ctrl.wrResult = 1'b1;
        end
        OP_SUB: begin
          ctrl.fire = 1'b1; ctrl.arith = 1'b1; ctrl.isSub = 1'b1;
          ctrl.wrResult = 1'b1;
        end
        OP_CMP: begin
          ctrl.fire = 1'b1; ctrl.arith = 1'b1; ctrl.isSub = 1'b1;
          ctrl.setM = 1'b1;
        end
        OP_AND: begin
          ctrl.fire = 1'b1; ctrl.logicOp = 1'b1; ctrl.wrResult = 1'b1;
          ctrl.forceC = 1'b1; ctrl.forceCVal = 1'b1;
        end
        OP_XOR: begin
          ctrl.fire = 1'b1; ctrl.logicOp = 1'b1; ctrl.useXor = 1'b1;
          ctrl.wrResult = 1'b1; ctrl.forceC = 1'b1; ctrl.forceCVal = 1'b0;
        end
        OP_LOAD: begin
          ctrl.fire = 1'b1; ctrl.passOperand = 1'b1; ctrl.wrResult = 1'b1;
          ctrl.clearV = 1'b1;
        end
        OP_STORE: begin
          ctrl.fire = 1'b1; ctrl.wrResult = 1'b1; ctrl.clearV = 1'b1;
        end
        default: ;
      endcase
    end
    ctrl.clrM    = callStrobe;
    ctrl.restore = restoreEn;
    ctrl.bitWr   = bitWrEn && (int'(bitIdx) < CR_W);
  end

endmodule

// File: rtl/mlaluDatapath.sv
module mlaluDatapath
  import mlalu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CR_W   = 7,
  localparam int IDX_W = $clog2(CR_W + 1),
  localparam int RST_W = CR_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [RST_W-1:0]  restoreData,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              bitVal,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic [CR_W-1:0]   condReg
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] addB;
  logic              carryIn;
  logic [DATA_W:0]   addSum;
  logic              ovfAdd;
  logic              ovfSub;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] outVal;
  logic [CR_W-1:0]   crNext;

  // adder: subtract is operand + ~acc + cin, where cin = M ? C : 1
  always_comb begin
    addB    = ctrl.isSub ? ~accIn : accIn;
    if (ctrl.isSub) carryIn = condReg[FLAG_M] ? condReg[FLAG_C] : 1'b1;
    else            carryIn = condReg[FLAG_M] & condReg[FLAG_C];
    addSum  = {1'b0, operandIn} + {1'b0, addB} + {{DATA_W{1'b0}}, carryIn};
  end

  always_comb begin
    ovfAdd = (operandIn[MSB] == accIn[MSB]) && (addSum[MSB] != accIn[MSB]);
    ovfSub = (operandIn[MSB] != accIn[MSB]) && (addSum[MSB] == accIn[MSB]);
  end

  assign logicRes = ctrl.useXor ? (accIn ^ operandIn) : (accIn & operandIn);

  always_comb begin
    if (ctrl.arith)            outVal = addSum[DATA_W-1:0];
    else if (ctrl.logicOp)     outVal = logicRes;
    else if (ctrl.passOperand) outVal = operandIn;
    else                       outVal = accIn;
  end

  // flag update, then call, then restore, then single bit write
  always_comb begin
    crNext = condReg;
    if (ctrl.fire) begin
      crNext[FLAG_Z] = (outVal == '0);
      crNext[FLAG_S] = outVal[MSB];
      if (ctrl.arith) begin
        crNext[FLAG_C] = addSum[DATA_W];
        crNext[FLAG_V] = ctrl.isSub ? ovfSub : ovfAdd;
      end
      if (ctrl.forceC) crNext[FLAG_C] = ctrl.forceCVal;
      if (ctrl.clearV) crNext[FLAG_V] = 1'b0;
      if (ctrl.setM)   crNext[FLAG_M] = 1'b1;
    end
    if (ctrl.clrM)    crNext[FLAG_M] = 1'b0;
    if (ctrl.restore) crNext[RST_W-1:0] = restoreData;
    if (ctrl.bitWr)   crNext[bitIdx] = bitVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      condReg     <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      condReg     <= crNext;
      resultValid <= ctrl.wrResult;
      if (ctrl.wrResult) result <= outVal;
    end
  end

endmodule

// File: rtl/multiLengthAlu.sv
module multiLengthAlu
  import mlalu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CR_W   = 7,
  localparam int IDX_W = $clog2(CR_W + 1),
  localparam int RST_W = CR_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic              callStrobe,
  input  logic              restoreEn,
  input  logic [RST_W-1:0]  restoreData,
  input  logic              bitWrEn,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              bitVal,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic [CR_W-1:0]   condReg
);

  aluCtrl_t ctrl;

  mlaluCtrl #(.CR_W(CR_W)) u_ctrl (
    .opValid    (opValid),
    .opCode     (opCode),
    .callStrobe (callStrobe),
    .restoreEn  (restoreEn),
    .bitWrEn    (bitWrEn),
    .bitIdx     (bitIdx),
    .ctrl       (ctrl)
  );

  mlaluDatapath #(.DATA_W(DATA_W), .CR_W(CR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .accIn       (accIn),
    .operandIn   (operandIn),
    .restoreData (restoreData),
    .bitIdx      (bitIdx),
    .bitVal      (bitVal),
    .result      (result),
    .resultValid (resultValid),
    .condReg     (condReg)
  );

endmodule

// File: rtl/mlaluChecker.sv
module mlaluChecker #(
  parameter int DATA_W = 16,
  parameter int CR_W   = 7,
  localparam int IDX_W = $clog2(CR_W + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        opCode,
  input logic              callStrobe,
  input logic              restoreEn,
  input logic              bitWrEn,
  input logic [IDX_W-1:0]  bitIdx,
  input logic              bitVal,
  input logic [DATA_W-1:0] result,
  input logic              resultValid,
  input logic [CR_W-1:0]   condReg
);

  logic noOverride;
  assign noOverride = !restoreEn && !bitWrEn;

  p_cmp_sets_m_r3: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == 3'd2 && noOverride && !callStrobe |=> condReg[5]);

  p_cmp_no_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == 3'd2 |=> !resultValid && $stable(result));

  p_and_sets_c_r4: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == 3'd3 && noOverride |=> condReg[4]);

  p_xor_clears_c_r4: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == 3'd4 && noOverride |=> !condReg[4]);

  p_move_clears_v_r5: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (opCode == 3'd5 || opCode == 3'd6) && noOverride |=> !condReg[2]);

  p_add_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == 3'd0 |=> resultValid);

  p_no_strobe_no_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resultValid);

  p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !opValid && !callStrobe && noOverride |=> $stable(condReg) && $stable(result));

  p_call_clears_m_r8: assert property (@(posedge clk) disable iff (!rstN)
    callStrobe && noOverride |=> !condReg[5]);

  p_restore_keeps_fail_r9: assert property (@(posedge clk) disable iff (!rstN)
    restoreEn && !bitWrEn |=> condReg[6] == $past(condReg[6]));

  p_bit_write_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    bitWrEn && int'(bitIdx) < CR_W |=> condReg[$past(bitIdx)] == $past(bitVal));

endmodule

bind multiLengthAlu mlaluChecker #(.DATA_W(DATA_W), .CR_W(CR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .opValid     (opValid),
  .opCode      (opCode),
  .callStrobe  (callStrobe),
  .restoreEn   (restoreEn),
  .bitWrEn     (bitWrEn),
  .bitIdx      (bitIdx),
  .bitVal      (bitVal),
  .result      (result),
  .resultValid (resultValid),
  .condReg     (condReg)
);

// File: tb/multiLengthAlu_bench.sv
`timescale 1ns/1ps
module multiLengthAlu_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [15:0] accIn = '0;
  logic [15:0] operandIn = '0;
  logic        callStrobe = 1'b0;
  logic        restoreEn = 1'b0;
  logic [5:0]  restoreData = '0;
  logic        bitWrEn = 1'b0;
  logic [2:0]  bitIdx = '0;
  logic        bitVal = 1'b0;
  logic [15:0] result;
  logic        resultValid;
  logic [6:0]  condReg;

  always #2 clk = ~clk;

  multiLengthAlu u_multiLengthAlu (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .accIn(accIn), .operandIn(operandIn), .callStrobe(callStrobe),
    .restoreEn(restoreEn), .restoreData(restoreData), .bitWrEn(bitWrEn),
    .bitIdx(bitIdx), .bitVal(bitVal), .result(result),
    .resultValid(resultValid), .condReg(condReg)
  );

  typedef struct {
    logic [15:0] res;
    logic        vld;
    logic [6:0]  cr;
    string       tag;
  } item_t;

  item_t expQ[$];
  int    nTests = 0;
  int    nFail  = 0;
  bit    done   = 1'b0;

  // bench model state
  logic [6:0]  mCr  = '0;
  logic [15:0] mRes = '0;

  // monitor: compares one item per clock, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      nTests++;
      if (result !== it.res || resultValid !== it.vld || condReg !== it.cr) begin
        nFail++;
        $display("FAIL %s: got res=%h vld=%b cr=%b, expected res=%h vld=%b cr=%b",
                 it.tag, result, resultValid, condReg, it.res, it.vld, it.cr);
      end
    end
  end

  // driver: applies one cycle of stimulus and pushes the expected outcome
  task automatic step(input int op, input logic [15:0] a, input logic [15:0] b,
                      input bit strobe, input bit call, input bit rest,
                      input logic [5:0] rdat, input bit bw, input logic [2:0] bi,
                      input bit bv, input string tag);
    item_t it;
    logic [6:0] nCr;
    logic [15:0] r;
    bit vld;
    int m, c, s;
    @(negedge clk);
    opValid = strobe; opCode = op[2:0]; accIn = a; operandIn = b;
    callStrobe = call; restoreEn = rest; restoreData = rdat;
    bitWrEn = bw; bitIdx = bi; bitVal = bv;
    nCr = mCr; vld = 1'b0; r = 16'h0;
    m = mCr[5]; c = mCr[4];
    if (strobe && op != 7) begin
      case (op)
        0: begin
          s = int'(b) + int'(a) + (m ? c : 0);
          r = s[15:0]; nCr[4] = (s > 65535);
          nCr[2] = (a[15] == b[15]) && (r[15] != a[15]);
        end
        1, 2: begin
          s = int'(b) - int'(a) - (m ? (1 - c) : 0);
          r = s[15:0]; nCr[4] = (s >= 0);
          nCr[2] = (a[15] != b[15]) && (r[15] == a[15]);
          if (op == 2) nCr[5] = 1'b1;
        end
        3: begin r = a & b; nCr[4] = 1'b1; end
        4: begin r = a ^ b; nCr[4] = 1'b0; end
        5: begin r = b; nCr[2] = 1'b0; end
        default: begin r = a; nCr[2] = 1'b0; end
      endcase
      nCr[1] = (r == 16'h0);
      nCr[3] = r[15];
      if (op != 2) begin vld = 1'b1; mRes = r; end
    end
    if (call) nCr[5] = 1'b0;
    if (rest) nCr[5:0] = rdat;
    if (bw && bi != 3'd7) nCr[bi] = bv;
    mCr = nCr;
    it.res = mRes; it.vld = vld; it.cr = mCr; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic aluOp(input int op, input logic [15:0] a, input logic [15:0] b,
                       input string tag);
    step(op, a, b, 1, 0, 0, 6'h0, 0, 3'd0, 0, tag);
  endtask

  task automatic idle(input string tag);
    step(0, 16'h0, 16'h0, 0, 0, 0, 6'h0, 0, 3'd0, 0, tag);
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    nTests++;
    if (result !== 16'h0 || resultValid !== 1'b0 || condReg !== 7'h0) begin
      nFail++;
      $display("FAIL R11: got res=%h vld=%b cr=%b, expected all zero",
               result, resultValid, condReg);
    end
    @(negedge clk); rstN = 1'b1;

    aluOp(0, 16'h0001, 16'h1234, "R1 add plain");
    aluOp(0, 16'h0001, 16'hFFFF, "R1 add carry out, R6 zero");
    aluOp(0, 16'h0001, 16'h7FFF, "R1 add overflow");
    aluOp(1, 16'h0003, 16'h0005, "R2 sub no borrow");
    aluOp(1, 16'h0005, 16'h0003, "R2 sub borrow");
    aluOp(1, 16'h0001, 16'h8000, "R2 sub overflow");
    aluOp(2, 16'h0010, 16'h0010, "R3 compare equal sets M");
    aluOp(1, 16'h0004, 16'h0009, "R2 multi sub carry set");
    aluOp(1, 16'h0001, 16'h0000, "R2 multi sub borrow");
    aluOp(1, 16'h0002, 16'h0007, "R2 multi sub carry clear");
    aluOp(2, 16'h8000, 16'h0001, "R3 compare overflow");
    aluOp(3, 16'hF0F0, 16'h0FF0, "R4 and forces C, keeps V");
    aluOp(0, 16'h0001, 16'h0002, "R1 multi add with C");
    aluOp(4, 16'hFFFF, 16'h00FF, "R4 xor clears C");
    aluOp(0, 16'hFFFF, 16'h0001, "R1 multi add C clear");
    aluOp(0, 16'h4000, 16'h4000, "R1 set V before load");
    aluOp(5, 16'h8000, 16'h0000, "R5 load zero");
    aluOp(6, 16'h8001, 16'h0000, "R5 store negative");
    aluOp(7, 16'h1111, 16'h2222, "R7 undefined code ignored");
    idle("R7 idle holds");
    step(0, 0, 0, 0, 1, 0, 6'h0, 0, 3'd0, 0, "R8 call clears M");
    step(0, 0, 0, 0, 0, 0, 6'h0, 1, 3'd6, 1, "R10 set fail flag");
    step(0, 0, 0, 0, 0, 1, 6'h3F, 0, 3'd0, 0, "R9 restore all ones");
    step(0, 0, 0, 0, 0, 1, 6'h00, 0, 3'd0, 0, "R9 restore keeps fail");
    step(2, 16'h0001, 16'h0002, 1, 0, 0, 6'h0, 1, 3'd5, 0, "R10 bit write beats compare");
    aluOp(2, 16'h0001, 16'h0001, "R3 compare sets M again");
    step(0, 16'h0001, 16'hFFFF, 1, 1, 0, 6'h0, 0, 3'd0, 0, "R8 call with add");
    step(0, 0, 0, 0, 0, 0, 6'h0, 1, 3'd7, 1, "R10 index 7 ignored");
    step(0, 0, 0, 0, 0, 1, 6'h2A, 1, 3'd6, 0, "R9 R10 restore with fail clear");
    step(3, 16'hFFFF, 16'h8000, 1, 0, 1, 6'h01, 0, 3'd0, 0, "R9 restore after and");
    idle("R7 final idle");
    idle("R7 final idle");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule